// File: doc/BRIEF.md
# Mode-Based Memory Bank Mapper

This block sits between a CPU with a 16-bit address bus and five memories: the boot ROM, the interpreter ROM, the extension ROM, a 256 KB banked RAM and a 2 KB shared RAM. For each access it names the target memory, gives the physical offset inside that memory and raises the write strobe. It decides these from the address and from three small registers that the CPU loads over its I/O bus. The address is split into 2 KB pages, with bits 15:11 as the page and bits 10:0 as the place in the page.

A 2-bit layout mode picks one of four maps. Mode 0 is the power-up map, with the boot ROM mirrored in the low 8 KB. Mode 1 is almost all RAM, for loading a system. Mode 2 is the ROM interpreter map. Mode 3 is the RAM interpreter map. Two window selectors choose what appears at 0x2000-0x3FFF and at 0xC000-0xFFFF. Value 0xF of the upper selector leaves only the top 2 KB page mapped, and that page goes to shared RAM. Writes that land on ROM or on unmapped space are dropped. Reads from unmapped space return 0xFF. Otherwise the byte from the selected memory passes through.

Top module: `bank_mapper`

## Requirements
- R1: After reset the mode, the upper window selector and the lower window selector are all 0. So address 0x0000 maps to the boot ROM at offset 0x1000, and address 0xC000 maps to RAM at offset 0xC000.
- R2: An I/O write to port MAP_PORT (default 0xFE) loads the mode from data bits 1:0 and the upper selector from bits 7:4. Bits 3:2 are ignored. A write to WIN_PORT (default 0xFD) loads the lower selector from bits 2:0. Writes to any other port change nothing. A loaded value applies to accesses from the next cycle on.
- R3: In mode 0, addresses 0x0000-0x1FFF map to the boot ROM at 0x1000 + (address mod 0x1000). Addresses 0x2000-0x3FFF map to the interpreter ROM and 0x4000-0xBFFF map to RAM, both at an offset equal to the address.
- R4: In mode 0, addresses 0xC000-0xFFFF follow the upper selector. Value 0 gives RAM at an offset equal to the address. Value 1 gives RAM at address - 0xC000. Value 15 gives shared RAM at address - 0xF800 for 0xF800-0xFFFF and leaves 0xC000-0xF7FF unmapped. Every other value leaves the window unmapped.
- R5: In mode 1, addresses below 0xF800 map to RAM at an offset equal to the address, and 0xF800-0xFFFF map to shared RAM at address - 0xF800.
- R6: In mode 2, addresses 0x0000-0x1FFF map to the interpreter ROM at an offset equal to the address. At 0x2000-0x3FFF, with L the lower selector and x = address - 0x2000: L = 0..2 gives the interpreter ROM at 0x2000·(L+1) + x, L = 3..6 gives the extension ROM at 0x2000·(L-3) + x, and L = 7 is unmapped.
- R7: In mode 2, 0x4000-0xBFFF is RAM at an offset equal to the address. At 0xC000-0xFFFF, with H the upper selector and y = address - 0xC000: H = 0 and H = 1 behave as in mode 0, H = 2..13 gives RAM at 0x10000 + 0x4000·(H-2) + y, H = 15 behaves as in mode 0, and H = 14 is unmapped.
- R8: In mode 3, 0x0000-0x1FFF and 0x4000-0xBFFF are RAM at an offset equal to the address. At 0x2000-0x3FFF, with x = address - 0x2000: L = 0 gives RAM at 0x2000 + x, L = 1 gives RAM at 0xC000 + x, L = 2 gives RAM at 0xE000 + x, L = 3..6 behave as in mode 2, and L = 7 is unmapped.
- R9: In mode 3, at 0xC000-0xFFFF: H = 0..11 gives RAM at 0x10000 + 0x4000·H + y, H = 15 gives the top-page shared RAM as in mode 0, and H = 12..14 are unmapped.
- R10: `mem_we` is high only when `cpu_wr` is high and the target is RAM (code 4) or shared RAM (code 5). For the boot ROM (1), the interpreter ROM (2), the extension ROM (3) and unmapped space (0), `mem_we` stays low.
- R11: For an unmapped access the target is 0, the offset is 0 and `cpu_rdata` is 0xFF. For a mapped access `cpu_rdata` equals `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| cpu_addr | input | 16 | CPU memory address |
| cpu_wr | input | 1 | CPU memory write request |
| mem_rdata | input | 8 | Read byte from the selected memory |
| mem_sel | output | 3 | Target: 0 none, 1 boot ROM, 2 interpreter ROM, 3 extension ROM, 4 RAM, 5 shared RAM |
| mem_off | output | 18 | Physical offset inside the target |
| mem_we | output | 1 | Write strobe to the target |
| cpu_rdata | output | 8 | Read byte returned to the CPU |

## Verification
The assertions assume two things about the inputs. First, each I/O write is a single-cycle strobe with `io_addr` and `io_wdata` stable while `io_wr` is high. Second, `cpu_addr` and `cpu_wr` are plain levels, so the map can be checked combinationally in the same cycle. The stimulus drives every input at the falling edge and holds `io_wr` high for exactly one rising edge. A register change is therefore seen only by the probes issued after that edge. The sweep covers every mode, every value of both selectors and every page, with reads and writes alternated. Extra writes to unused ports and to the ignored data bits exercise the cases where nothing should change.

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter logic [7:0] MAP_PORT = 8'hFE,
  parameter logic [7:0] WIN_PORT = 8'hFD,
  parameter int OFF_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic [7:0]       io_addr,
  input  logic [7:0]       io_wdata,
  input  logic [15:0]      cpu_addr,
  input  logic             cpu_wr,
  input  logic [7:0]       mem_rdata,
  output logic [2:0]       mem_sel,
  output logic [OFF_W-1:0] mem_off,
  output logic             mem_we,
  output logic [7:0]       cpu_rdata
);
  localparam logic [2:0] T_NONE = 3'd0, T_BOOT = 3'd1, T_INTP = 3'd2,
                         T_EXT  = 3'd3, T_RAM  = 3'd4, T_SHR  = 3'd5;

  logic [1:0] mode_q;
  logic [3:0] hi_q;
  logic [2:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (io_wr) begin
      if (io_addr == MAP_PORT) begin
        mode_q <= io_wdata[1:0];
        hi_q   <= io_wdata[7:4];
      end
      if (io_addr == WIN_PORT) lo_q <= io_wdata[2:0];
    end
  end

  wire unused_bits = ^{io_wdata[3:2]};

  wire                 low8k = cpu_addr[15:13] == 3'd0;
  wire                 win2k = cpu_addr[15:13] == 3'd1;
  wire                 upper = cpu_addr[15:14] == 2'b11;
  wire                 top   = cpu_addr[15:11] == 5'h1F;
  wire [OFF_W-1:0]     a_f   = OFF_W'(cpu_addr);
  wire [OFF_W-1:0]     a_13  = OFF_W'(cpu_addr[12:0]);
  wire [OFF_W-1:0]     a_14  = OFF_W'(cpu_addr[13:0]);
  wire [OFF_W-1:0]     a_sh  = OFF_W'(cpu_addr[10:0]);
  wire [OFF_W-1:0]     ext_o = ((OFF_W'(lo_q) - OFF_W'(3)) << 13) + a_13;

  logic [2:0]       sel_c;
  logic [OFF_W-1:0] off_c;

  always_comb begin
    sel_c = T_NONE;
    off_c = '0;
    unique case (mode_q)
      2'd0: begin
        if (low8k)       begin sel_c = T_BOOT; off_c = OFF_W'({1'b1, cpu_addr[11:0]}); end
        else if (win2k)  begin sel_c = T_INTP; off_c = a_f; end
        else if (!upper) begin sel_c = T_RAM;  off_c = a_f; end
        else if (hi_q == 4'd0) begin sel_c = T_RAM; off_c = a_f; end
        else if (hi_q == 4'd1) begin sel_c = T_RAM; off_c = a_14; end
        else if (hi_q == 4'd15 && top) begin sel_c = T_SHR; off_c = a_sh; end
      end
      2'd1: begin
        if (!top) begin sel_c = T_RAM; off_c = a_f; end
        else      begin sel_c = T_SHR; off_c = a_sh; end
      end
      2'd2: begin
        if (low8k) begin sel_c = T_INTP; off_c = a_f; end
        else if (win2k) begin
          if (lo_q <= 3'd2)      begin sel_c = T_INTP; off_c = ((OFF_W'(lo_q) + OFF_W'(1)) << 13) + a_13; end
          else if (lo_q != 3'd7) begin sel_c = T_EXT;  off_c = ext_o; end
        end
        else if (!upper) begin sel_c = T_RAM; off_c = a_f; end
        else if (hi_q == 4'd0) begin sel_c = T_RAM; off_c = a_f; end
        else if (hi_q == 4'd1) begin sel_c = T_RAM; off_c = a_14; end
        else if (hi_q <= 4'd13) begin
          sel_c = T_RAM;
          off_c = OFF_W'(18'h10000) + ((OFF_W'(hi_q) - OFF_W'(2)) << 14) + a_14;
        end
        else if (hi_q == 4'd15 && top) begin sel_c = T_SHR; off_c = a_sh; end
      end
      2'd3: begin
        if (low8k) begin sel_c = T_RAM; off_c = a_f; end
        else if (win2k) begin
          if (lo_q == 3'd0)      begin sel_c = T_RAM; off_c = a_f; end
          else if (lo_q == 3'd1) begin sel_c = T_RAM; off_c = OFF_W'(18'hC000) + a_13; end
          else if (lo_q == 3'd2) begin sel_c = T_RAM; off_c = OFF_W'(18'hE000) + a_13; end
          else if (lo_q != 3'd7) begin sel_c = T_EXT; off_c = ext_o; end
        end
        else if (!upper) begin sel_c = T_RAM; off_c = a_f; end
        else if (hi_q <= 4'd11) begin
          sel_c = T_RAM;
          off_c = OFF_W'(18'h10000) + (OFF_W'(hi_q) << 14) + a_14;
        end
        else if (hi_q == 4'd15 && top) begin sel_c = T_SHR; off_c = a_sh; end
      end
      default: ;
    endcase
  end

  assign mem_sel   = sel_c;
  assign mem_off   = off_c;
  assign mem_we    = cpu_wr && (sel_c == T_RAM || sel_c == T_SHR);
  assign cpu_rdata = (sel_c == T_NONE) ? 8'hFF : mem_rdata;

  // R2
  map_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == MAP_PORT) |=> (mode_q == $past(io_wdata[1:0]) && hi_q == $past(io_wdata[7:4])));

  // R2
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable({mode_q, hi_q, lo_q}));

  // R10
  rom_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel == T_BOOT || mem_sel == T_INTP || mem_sel == T_EXT || mem_sel == T_NONE) |-> !mem_we);

  // R11
  unmapped_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel == T_NONE) |-> (cpu_rdata == 8'hFF && mem_off == '0));

  // R5
  shared_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel == T_SHR) |-> (cpu_addr[15:11] == 5'h1F && mem_off < OFF_W'(2048)));
endmodule

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [2:0]  mem_sel;
  logic [17:0] mem_off;
  logic        mem_we;
  logic [7:0]  cpu_rdata;

  int checks = 0;
  int fails = 0;
  int m_mode = 0, m_hi = 0, m_lo = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bank_mapper u_bank_mapper (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .mem_rdata(mem_rdata),
    .mem_sel(mem_sel), .mem_off(mem_off), .mem_we(mem_we), .cpu_rdata(cpu_rdata)
  );

  function automatic void ref_map(input int a, output int t, output int o, output string rq);
    int x = a - 'h2000;
    int y = a - 'hC000;
    t = 0; o = 0; rq = "R11";
    case (m_mode)
      0: begin
        if (a < 'h2000)      begin t = 1; o = 'h1000 + a % 'h1000; rq = "R3"; end
        else if (a < 'h4000) begin t = 2; o = a; rq = "R3"; end
        else if (a < 'hC000) begin t = 4; o = a; rq = "R3"; end
        else begin
          rq = "R4";
          if (m_hi == 0) begin t = 4; o = a; end
          else if (m_hi == 1) begin t = 4; o = y; end
          else if (m_hi == 15 && a >= 'hF800) begin t = 5; o = a - 'hF800; end
        end
      end
      1: begin
        rq = "R5";
        if (a < 'hF800) begin t = 4; o = a; end else begin t = 5; o = a - 'hF800; end
      end
      2: begin
        if (a < 'h2000) begin t = 2; o = a; rq = "R6"; end
        else if (a < 'h4000) begin
          rq = "R6";
          if (m_lo < 3) begin t = 2; o = 'h2000 * (m_lo + 1) + x; end
          else if (m_lo < 7) begin t = 3; o = 'h2000 * (m_lo - 3) + x; end
        end
        else if (a < 'hC000) begin t = 4; o = a; rq = "R7"; end
        else begin
          rq = "R7";
          if (m_hi == 0) begin t = 4; o = a; end
          else if (m_hi == 1) begin t = 4; o = y; end
          else if (m_hi <= 13) begin t = 4; o = 'h10000 + 'h4000 * (m_hi - 2) + y; end
          else if (m_hi == 15 && a >= 'hF800) begin t = 5; o = a - 'hF800; end
        end
      end
      default: begin
        if (a < 'h2000) begin t = 4; o = a; rq = "R8"; end
        else if (a < 'h4000) begin
          rq = "R8";
          if (m_lo == 0) begin t = 4; o = a; end
          else if (m_lo == 1) begin t = 4; o = 'hC000 + x; end
          else if (m_lo == 2) begin t = 4; o = 'hE000 + x; end
          else if (m_lo < 7) begin t = 3; o = 'h2000 * (m_lo - 3) + x; end
        end
        else if (a < 'hC000) begin t = 4; o = a; rq = "R8"; end
        else begin
          rq = "R9";
          if (m_hi < 12) begin t = 4; o = 'h10000 + 'h4000 * m_hi + y; end
          else if (m_hi == 15 && a >= 'hF800) begin t = 5; o = a - 'hF800; end
        end
      end
    endcase
    if (t == 0) rq = "R11";
  endfunction

  task automatic io_write(input logic [7:0] port, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = port; io_wdata = d;
    @(posedge clk);
    if (port == 8'hFE) begin m_mode = int'(d[1:0]); m_hi = int'(d[7:4]); end
    if (port == 8'hFD) m_lo = int'(d[2:0]);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic probe(input int a, input bit wr, input string tag_over);
    int et, eo, ewe, erd;
    string rq;
    @(negedge clk);
    cpu_addr = a[15:0]; cpu_wr = wr; mem_rdata = a[7:0] ^ 8'h5A;
    #5;
    ref_map(a, et, eo, rq);
    if (wr && (et == 1 || et == 2 || et == 3)) rq = "R10";
    if (tag_over != "") rq = tag_over;
    ewe = (wr && (et == 4 || et == 5)) ? 1 : 0;
    erd = (et == 0) ? 'hFF : int'(a[7:0] ^ 8'h5A);
    checks++;
    if (int'(mem_sel) != et || int'(mem_off) != eo || int'(mem_we) != ewe || int'(cpu_rdata) != erd) begin
      fails++;
      $display("FAIL %s addr=%h mode=%0d hi=%0d lo=%0d got sel=%0d off=%h we=%0d rd=%h exp sel=%0d off=%h we=%0d rd=%h",
               rq, a, m_mode, m_hi, m_lo, mem_sel, mem_off, mem_we, cpu_rdata, et, eo, ewe, erd);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values of all three registers
    probe('h0000, 0, "R1");
    probe('h0FFF, 1, "R1");
    probe('hC000, 1, "R1");
    probe('hFFFF, 0, "R1");
    // R2: ignored port and ignored data bits leave the map unchanged
    io_write(8'h12, 8'hFF);
    probe('hC123, 1, "R2");
    io_write(8'hFE, 8'h1E);
    probe('hC123, 0, "R2");
    probe('hF900, 1, "R2");
    io_write(8'hFD, 8'hF9);
    io_write(8'hFE, 8'h03);
    probe('h2345, 0, "R2");
    for (int md = 0; md < 4; md++) begin
      for (int lw = 0; lw < 8; lw++) begin
        io_write(8'hFD, {5'b10101, lw[2:0]});
        for (int hw = 0; hw < 16; hw++) begin
          io_write(8'hFE, {hw[3:0], 2'b11, md[1:0]});
          for (int p = 0; p < 32; p++) begin
            probe(p * 2048, 0, "");
            probe(p * 2048 + ((p * 37 + hw * 13 + lw) & 'h7FF), 1, "");
            if (p == 31 || p == 7 || p == 23) probe(p * 2048 + 'h7FF, (hw % 2) == 1, "");
          end
        end
      end
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule